// File: doc/BRIEF.md
# MDIO Management Controller

This block is a serial management master for PHY devices. Software sets up a small register file with a divider, a PHY address, a register address and (for writes) a 16-bit data word, then writes a command word that starts a single read, a single write, or a continuous scan. The controller derives the management clock from the system clock, shifts the management frame out MSB first, releases the data line for the turnaround and data field of a read, captures the returned 16 bits into a receive register, and reports progress through a status register.

The scan command keeps issuing back-to-back reads of the selected PHY register for as long as its bit stays set. After each scan read the link-fail flag is refreshed from one bit of the value read, so link monitoring needs no software polling. An optional mode drops the 32-bit preamble to shorten every frame.

The register port is a plain write strobe with an index and a combinational read mux. A write takes effect on the clock edge where the strobe is high. There is no stall and no back-pressure: software checks the busy flag instead. The serial side is the management clock, a data output, its output enable and a data input.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset every register reads zero, the management clock is low and the data output enable is low.
- R2: The register indices are 0 mode, 1 command, 2 address, 3 transmit data, 4 receive data (read-only) and 5 status (read-only). Mode keeps the divider in bits 7:0 and preamble suppression in bit 8. Address keeps the PHY address in bits 4:0 and the register address in bits 12:8. Transmit data uses bits 15:0. Unused bits read as zero.
- R3: A write command (command bit 2) sends 32 preamble ones, start 01, opcode 01, the PHY address, the register address, turnaround 10 and the 16 transmit-data bits, all MSB first, with the output enable high for the whole frame.
- R4: A read command (command bit 1) sends opcode 10 and drops the output enable for the turnaround and the 16 data bits. It samples the data input on management-clock rising edges, MSB first, and the value appears in the receive data register.
- R5: With mode bit 8 set, a frame starts directly with the start bits and has no preamble ones.
- R6: The management clock period is the divider with bit 0 cleared, in system clocks. Any result below 2 counts as 2. The clock is high for half of the period and is held low while no frame runs.
- R7: The data output and its enable change only while the management clock is low (at its falling edge). Both stay stable while the clock is high.
- R8: Status bit 1 (busy) is set from the first cycle after a read or write command is written until its frame ends. While busy is clear, the management clock and the output enable are low.
- R9: When command bits 1 and 2 are written together, a write frame is sent.
- R10: While command bit 0 (scan) is set, read frames of the selected register repeat back to back and busy stays set. After the bit is cleared, the frame in progress finishes and no further frame starts.
- R11: Writing the scan bit from 0 to 1 sets status bit 2 (invalid) until the first scan read finishes. Each finished scan read sets status bit 0 (link fail) to the inverse of bit 2 of the value read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current index |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The properties assume that reset is asserted before the first clock edge and that the divider in the mode register is changed only while busy is clear. A divider changed in the middle of a frame would move the clock edges under a running counter. No property constrains the data input, because it is sampled only at management-clock rising edges and it only affects captured values. The directed stimulus reprograms the mode register only after waiting for busy to clear. A PHY model drives the data input only after a falling edge of the management clock during the data field of a read, and otherwise holds it high as an idle pull-up would.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  parameter int PHYA_W  = 5;
  parameter int REGA_W  = 5;
  parameter int DATA_W  = 16;
  parameter int DIV_W   = 8;
  parameter int PRE_LEN = 32;
  parameter int REG_W   = 32;
  parameter int IDX_AW  = 3;

  // start(2) + opcode(2) + phy + reg + turnaround(2) + data
  localparam int FRAME_W = 6 + PHYA_W + REGA_W + DATA_W;
  localparam int TOTAL_W = PRE_LEN + FRAME_W;

  // field positions (R2)
  localparam int MODE_NOPRE_BIT = 8;
  localparam int ADDR_REG_LSB   = 8;
  localparam int CMD_SCAN       = 0;
  localparam int CMD_RD         = 1;
  localparam int CMD_WR         = 2;
  localparam int STAT_LINK      = 0;
  localparam int STAT_BUSY      = 1;
  localparam int STAT_INV       = 2;
  localparam int LINK_UP_BIT    = 2;

  typedef enum logic [IDX_AW-1:0] {
    REG_MODE = 3'd0,
    REG_CMD  = 3'd1,
    REG_ADDR = 3'd2,
    REG_TXD  = 3'd3,
    REG_RXD  = 3'd4,
    REG_STAT = 3'd5
  } reg_idx_e;

  typedef struct packed {
    logic              wr;
    logic              scan;
    logic              nopre;
    logic [PHYA_W-1:0] phy;
    logic [REGA_W-1:0] regad;
    logic [DATA_W-1:0] data;
  } xfer_req_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
// Management clock generator: period = even divider (min 2), half high.
module mdio_mdc_gen
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_raw,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] even_div;
  logic [DIV_W-1:0] period;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;

  // R6: clear bit 0, clamp to 2
  always_comb begin
    even_div = {div_raw[DIV_W-1:1], 1'b0};
    period   = (even_div < DIV_W'(2)) ? DIV_W'(2) : even_div;
    half     = period >> 1;
  end

  assign rise_evt = run && (cnt_q == half - DIV_W'(1));
  assign fall_evt = run && (cnt_q == period - DIV_W'(1));
  assign mdc      = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= fall_evt ? '0 : cnt_q + DIV_W'(1);
      if (rise_evt)      mdc_q <= 1'b1;
      else if (fall_evt) mdc_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
// Frame engine: shifts one management frame out, captures read data.
module mdio_frame_shifter
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  xfer_req_t         req,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done_rd,
  output logic              done_scan,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(TOTAL_W);
  localparam logic [IDX_W-1:0] IDX_FULL  = IDX_W'(TOTAL_W - 1);
  localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] IDX_TA    = IDX_W'(DATA_W + 2);
  localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(DATA_W);

  logic [TOTAL_W-1:0] tx_q;
  logic [IDX_W-1:0]   idx_q;
  logic               active_q;
  logic               wr_q;
  logic               scan_q;
  logic [DATA_W-1:0]  rx_sh;
  logic               last_bit;
  logic [TOTAL_W-1:0] tx_load;

  // R3/R4: frame image, MSB sent first
  always_comb begin
    tx_load = {{PRE_LEN{1'b1}}, 2'b01,
               (req.wr ? 2'b01 : 2'b10),
               req.phy, req.regad,
               (req.wr ? 2'b10 : 2'b00),
               (req.wr ? req.data : {DATA_W{1'b0}})};
  end

  assign last_bit = active_q && fall_evt && (idx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      scan_q   <= 1'b0;
      rx_sh    <= '0;
    end else if (start && !active_q) begin
      tx_q     <= tx_load;
      idx_q    <= req.nopre ? IDX_SHORT : IDX_FULL; // R5
      active_q <= 1'b1;
      wr_q     <= req.wr;
      scan_q   <= req.scan;
    end else if (active_q) begin
      // R4: sample on the rising edge during the data field
      if (rise_evt && !wr_q && (idx_q < IDX_DATA))
        rx_sh <= {rx_sh[DATA_W-2:0], mdio_i};
      // R7: advance only on the falling edge
      if (fall_evt) begin
        if (idx_q == '0) active_q <= 1'b0;
        else             idx_q    <= idx_q - IDX_W'(1);
      end
    end
  end

  assign active    = active_q;
  assign mdio_oe   = active_q && (wr_q || (idx_q >= IDX_TA));
  assign mdio_o    = mdio_oe && tx_q[idx_q];
  assign done_rd   = last_bit && !wr_q;
  assign done_scan = last_bit && scan_q;
  assign rd_data   = rx_sh;
endmodule

// File: rtl/mdio_mgmt_regs.sv
// Register file, command arbitration and status.
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [IDX_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              eng_active,
  input  logic              eng_done_rd,
  input  logic              eng_done_scan,
  input  logic [DATA_W-1:0] eng_rx,
  output logic              eng_start,
  output xfer_req_t         eng_req,
  output logic [DIV_W-1:0]  div_raw,
  output logic [2:0]        stat_o
);
  logic [DIV_W-1:0]  div_q;
  logic              nopre_q;
  logic [2:0]        cmd_q;
  logic [PHYA_W-1:0] phy_q;
  logic [REGA_W-1:0] rga_q;
  logic [DATA_W-1:0] txd_q;
  logic [DATA_W-1:0] rxd_q;
  logic              pend_q;
  logic              pend_wr_q;
  logic              inv_q;
  logic              lfail_q;
  logic              wr_cmd;
  logic              new_op;
  logic              busy;

  assign wr_cmd = reg_we && (reg_addr == REG_CMD);
  assign new_op = wr_cmd && (reg_wdata[CMD_RD] || reg_wdata[CMD_WR]);

  // a queued single command goes before the next scan frame
  assign eng_start = !eng_active && (pend_q || cmd_q[CMD_SCAN]);

  always_comb begin
    eng_req.wr    = pend_q && pend_wr_q;   // R9
    eng_req.scan  = !pend_q;               // R10
    eng_req.nopre = nopre_q;
    eng_req.phy   = phy_q;
    eng_req.regad = rga_q;
    eng_req.data  = txd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      nopre_q   <= 1'b0;
      cmd_q     <= '0;
      phy_q     <= '0;
      rga_q     <= '0;
      txd_q     <= '0;
      rxd_q     <= '0;
      pend_q    <= 1'b0;
      pend_wr_q <= 1'b0;
      inv_q     <= 1'b0;
      lfail_q   <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          REG_MODE: begin
            div_q   <= reg_wdata[DIV_W-1:0];
            nopre_q <= reg_wdata[MODE_NOPRE_BIT];
          end
          REG_CMD:  cmd_q <= reg_wdata[2:0];
          REG_ADDR: begin
            phy_q <= reg_wdata[PHYA_W-1:0];
            rga_q <= reg_wdata[ADDR_REG_LSB +: REGA_W];
          end
          REG_TXD:  txd_q <= reg_wdata[DATA_W-1:0];
          default: ;
        endcase
      end
      if (eng_start && pend_q) pend_q <= 1'b0;
      if (new_op && !pend_q) begin
        pend_q    <= 1'b1;
        pend_wr_q <= reg_wdata[CMD_WR];
      end
      if (eng_done_rd) rxd_q <= eng_rx;    // R4
      // R11: link and validity from the scan read
      if (eng_done_scan) begin
        inv_q   <= 1'b0;
        lfail_q <= ~eng_rx[LINK_UP_BIT];
      end
      if (wr_cmd && reg_wdata[CMD_SCAN] && !cmd_q[CMD_SCAN])
        inv_q <= 1'b1;
    end
  end

  // R8
  assign busy    = pend_q || eng_active || cmd_q[CMD_SCAN];
  assign div_raw = div_q;

  always_comb begin
    stat_o            = '0;
    stat_o[STAT_LINK] = lfail_q;
    stat_o[STAT_BUSY] = busy;
    stat_o[STAT_INV]  = inv_q;
  end

  // R2: read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_MODE: begin
        reg_rdata[DIV_W-1:0]      = div_q;
        reg_rdata[MODE_NOPRE_BIT] = nopre_q;
      end
      REG_CMD:  reg_rdata[2:0] = cmd_q;
      REG_ADDR: begin
        reg_rdata[PHYA_W-1:0]              = phy_q;
        reg_rdata[ADDR_REG_LSB +: REGA_W]  = rga_q;
      end
      REG_TXD:  reg_rdata[DATA_W-1:0] = txd_q;
      REG_RXD:  reg_rdata[DATA_W-1:0] = rxd_q;
      REG_STAT: reg_rdata[2:0]        = stat_o;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// Top: MDIO management master.
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [IDX_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic              start_w;
  xfer_req_t         req_w;
  logic [DIV_W-1:0]  div_w;
  logic [2:0]        stat_w;
  logic              active_w;
  logic              rise_w;
  logic              fall_w;
  logic              done_rd_w;
  logic              done_scan_w;
  logic [DATA_W-1:0] rx_w;

  mdio_mgmt_regs i_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .eng_active    (active_w),
    .eng_done_rd   (done_rd_w),
    .eng_done_scan (done_scan_w),
    .eng_rx        (rx_w),
    .eng_start     (start_w),
    .eng_req       (req_w),
    .div_raw       (div_w),
    .stat_o        (stat_w)
  );

  mdio_mdc_gen i_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (active_w),
    .div_raw  (div_w),
    .mdc      (mdc),
    .rise_evt (rise_w),
    .fall_evt (fall_w)
  );

  mdio_frame_shifter i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_w),
    .req       (req_w),
    .rise_evt  (rise_w),
    .fall_evt  (fall_w),
    .mdio_i    (mdio_i),
    .active    (active_w),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done_rd   (done_rd_w),
    .done_scan (done_scan_w),
    .rd_data   (rx_w)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic [2:0] stat,
  input logic       scan_done
);
  // R7
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat[1] |-> (!mdc && !mdio_oe));

  // R11
  invalid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[2]) |-> $past(scan_done));

  // R11
  linkfail_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat[0]) |-> $past(scan_done));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .stat      (stat_w),
  .scan_done (done_scan_w)
);

// File: tb/test_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module test_mdio_mgmt_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // ---------------- PHY model ----------------
  logic [15:0] phy_val = 16'h0000;
  int          ones = 0, fb = 0, frames = 0, oe_err = 0, last_pre = 0;
  bit          in_frame = 1'b0, is_rd = 1'b0;
  logic [31:0] fr = '0, last_fr = '0;

  always @(posedge mdc) begin
    logic ln;
    ln = mdio_oe ? mdio_o : mdio_i;
    if (!in_frame) begin
      if (mdio_oe && mdio_o) ones <= ones + 1;
      else if (mdio_oe && !mdio_o) begin
        in_frame <= 1'b1; fb <= 1; fr <= '0; last_pre <= ones; ones <= 0;
        is_rd <= 1'b0;
      end
    end else begin
      if (fb == 3) is_rd <= (fr[0] && !ln);
      if (fb >= 14 && is_rd && mdio_oe) oe_err <= oe_err + 1;
      fr <= {fr[30:0], ln};
      if (fb == 31) begin
        in_frame <= 1'b0; fb <= 0; last_fr <= {fr[30:0], ln};
        frames <= frames + 1;
      end else fb <= fb + 1;
    end
  end

  always @(negedge mdc)
    mdio_i <= (in_frame && is_rd && fb >= 16) ? phy_val[31-fb] : 1'b1;

  // output-change-while-high monitor (R7)
  int   viol = 0;
  logic mdc_d = 1'b0, mo_d = 1'b0, oe_d = 1'b0;
  always @(posedge clk) begin
    if (mdc && mdc_d && (mdio_o !== mo_d || mdio_oe !== oe_d)) viol <= viol + 1;
    mdc_d <= mdc; mo_d <= mdio_o; oe_d <= mdio_oe;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd_reg(3'd5, s);
      if (!s[1]) break;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin
      rd_reg(3'(i), v);
      check(v == 0, "R1 register reset", v, 0);
    end
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 serial pins idle", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr_reg(3'd0, 32'hFFFF_FFFF); rd_reg(3'd0, v);
    check(v == 32'h1FF, "R2 mode readback", v, 32'h1FF);
    wr_reg(3'd2, 32'hFFFF_FFFF); rd_reg(3'd2, v);
    check(v == 32'h1F1F, "R2 address readback", v, 32'h1F1F);
    wr_reg(3'd3, 32'hFFFF_FFFF); rd_reg(3'd3, v);
    check(v == 32'hFFFF, "R2 txdata readback", v, 32'hFFFF);
    wr_reg(3'd0, 0); wr_reg(3'd2, 0); wr_reg(3'd3, 0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    wr_reg(3'd2, {19'd0, 5'h0A, 3'd0, 5'h13});
    wr_reg(3'd3, 32'h0000_A5C3);
    wr_reg(3'd1, 32'h4);
    rd_reg(3'd5, v);
    check(v[1] == 1'b1, "R8 busy after command", v[1], 1);
    wait_idle();
    wr_reg(3'd1, 0);
    check(last_pre == 32, "R3 preamble ones", last_pre, 32);
    check(last_fr[31:28] == 4'b0101, "R3 start and opcode", last_fr[31:28], 4'b0101);
    check(last_fr[27:23] == 5'h13, "R3 phy address", last_fr[27:23], 5'h13);
    check(last_fr[22:18] == 5'h0A, "R3 register address", last_fr[22:18], 5'h0A);
    check(last_fr[17:16] == 2'b10, "R3 turnaround", last_fr[17:16], 2'b10);
    check(last_fr[15:0] == 16'hA5C3, "R3 data", last_fr[15:0], 16'hA5C3);
    rd_reg(3'd5, v);
    check(v[1] == 1'b0 && mdc == 1'b0 && mdio_oe == 1'b0, "R8 idle after frame",
          {v[1], mdc, mdio_oe}, 0);
  endtask

  task automatic t_read(input logic nopre, input logic [15:0] val);
    logic [31:0] v;
    int e0;
    e0 = oe_err;
    phy_val = val;
    wr_reg(3'd0, nopre ? 32'h100 : 32'h0);
    wr_reg(3'd2, {19'd0, 5'h01, 3'd0, 5'h04});
    wr_reg(3'd1, 32'h2);
    wait_idle();
    wr_reg(3'd1, 0);
    rd_reg(3'd4, v);
    check(v == {16'd0, val}, "R4 read data captured", v, val);
    check(last_fr[29:28] == 2'b10, "R4 read opcode", last_fr[29:28], 2'b10);
    check(oe_err == e0, "R4 enable released in turnaround/data", oe_err - e0, 0);
    if (nopre) check(last_pre == 0, "R5 no preamble", last_pre, 0);
    else       check(last_pre == 32, "R5 preamble present", last_pre, 32);
    wr_reg(3'd0, 0);
  endtask

  task automatic t_div(input logic [7:0] raw, input int exp);
    int pmin, pmax, last, cyc, rises;
    bit prev;
    pmin = 1 << 20; pmax = 0; last = -1; cyc = 0; rises = 0; prev = 1'b0;
    wr_reg(3'd0, {24'd0, raw});
    wr_reg(3'd1, 32'h4);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (mdc && !prev) begin
        if (last >= 0) begin
          if (cyc - last < pmin) pmin = cyc - last;
          if (cyc - last > pmax) pmax = cyc - last;
        end
        last = cyc;
        rises++;
      end
      prev = mdc;
      cyc++;
      if (rises == 20) break;
    end
    wait_idle();
    wr_reg(3'd1, 0);
    check(pmin == exp && pmax == exp, $sformatf("R6 period for divider %0d", raw), pmax, exp);
    wr_reg(3'd0, 0);
  endtask

  task automatic t_both();
    wr_reg(3'd3, 32'h0000_1234);
    wr_reg(3'd1, 32'h6);
    wait_idle();
    wr_reg(3'd1, 0);
    check(last_fr[29:28] == 2'b01 && last_fr[15:0] == 16'h1234,
          "R9 write wins over read", last_fr[29:28], 2'b01);
  endtask

  task automatic t_scan();
    logic [31:0] v;
    int f0, f1;
    phy_val = 16'h0000;
    wr_reg(3'd2, {19'd0, 5'h01, 3'd0, 5'h02});
    f0 = frames;
    wr_reg(3'd1, 32'h1);
    rd_reg(3'd5, v);
    check(v[2:0] == 3'b110, "R11 invalid and busy at scan start", v[2:0], 3'b110);
    for (int i = 0; i < 5000; i++) begin
      rd_reg(3'd5, v);
      if (!v[2]) break;
    end
    check(v[2:0] == 3'b011, "R11 link fail after scan read of bit2=0", v[2:0], 3'b011);
    phy_val = 16'h0004;
    for (int i = 0; i < 5000; i++) begin
      rd_reg(3'd5, v);
      if (!v[0]) break;
    end
    check(v[2:0] == 3'b010, "R11 link ok after scan read of bit2=1", v[2:0], 3'b010);
    check(frames - f0 >= 2, "R10 repeated scan frames", frames - f0, 2);
    rd_reg(3'd4, v);
    check(v == 32'h0004, "R10 scan value in receive register", v, 32'h0004);
    wr_reg(3'd1, 0);
    wait_idle();
    f1 = frames;
    repeat (400) @(negedge clk);
    rd_reg(3'd5, v);
    check(frames == f1 && v[1] == 1'b0, "R10 scan stops after clear", frames - f1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_write();
    t_read(1'b0, 16'h3C5A);
    t_read(1'b1, 16'hC0F1);
    t_div(8'd6, 6);
    t_div(8'd7, 6);
    t_div(8'd1, 2);
    t_div(8'd0, 2);
    t_both();
    t_scan();
    check(viol == 0, "R7 output stable while clock high", viol, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule